// File: doc/BRIEF.md
# Serial-Clock Hold Sync and Power-Down Controller

This controller watches the idle level of an already synchronized serial read clock, and counts that level only at conversion-cycle boundaries. A read clock that is low between conversions is normal traffic and is ignored. A read clock that stays high at `SYNC_CYC` consecutive boundaries puts the converter into a synchronization hold. In that hold the modulator and filter are kept in reset, and the data pin is first driven low for one system clock and then forced high. If the high level lasts until `PD_CYC` consecutive boundaries, the controller also asserts power-down. A falling edge of the serial clock ends either state.

After release, and after reset, the filter must settle again. The controller passes the filter's data-ready strobe through only after `SETTLE_CYC` conversion boundaries have passed in run mode. The first strobe that gets through therefore marks settled data.

All interfaces are plain control levels and strobes. There is no valid/ready stream, so there is no back-pressure.

Top module: `sclk_idle_ctrl`

## Requirements
- R1: The hold count advances only on a cycle where `cyc_tick` is 1 and `sclk_s` is 1. It clears when a tick sees `sclk_s` at 0, and it clears on any falling edge of `sclk_s`. High runs that are broken by a low tick do not add together.
- R2: On the clock after the tick that completes `SYNC_CYC` (default 4) consecutive high boundaries, `mod_rst` goes to 1.
- R3: When the hold is entered, `pin_lo_req` is 1 for exactly one clock. `pin_hi_force` is then 1 for as long as the hold lasts. The two are never 1 together.
- R4: `pwr_dn` goes to 1 on the clock after the tick that completes `PD_CYC` (default 20) consecutive high boundaries. It never goes to 1 earlier, and it is 1 only while `mod_rst` is 1.
- R5: A falling edge of `sclk_s` while the controller is in hold or power-down clears `mod_rst`, `pwr_dn` and `pin_hi_force` on the next clock. While `sclk_s` stays high they stay set.
- R6: A high hold of at least `SYNC_CYC` but fewer than `PD_CYC` boundaries gives the sync hold with `pwr_dn` left at 0.
- R7: `rdy_out` equals `rdy_in` only in run mode, and only once `SETTLE_CYC` (default 5) ticks have passed in run mode since the last reset or release. At all other times it is 0.
- R8: Read clocking that toggles `sclk_s` between boundaries, but leaves it low at every tick, never asserts `mod_rst`.
- R9: After reset the controller is in run mode and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_s | input | 1 | Serial read clock, already synchronized to clk |
| cyc_tick | input | 1 | One-clock strobe at each conversion-cycle boundary |
| rdy_in | input | 1 | Raw data-ready strobe from the filter |
| mod_rst | output | 1 | Holds the modulator and filter in reset |
| pwr_dn | output | 1 | Power-down request |
| pin_lo_req | output | 1 | One-clock request to drive the data pin low |
| pin_hi_force | output | 1 | Forces the data pin high during the hold |
| rdy_out | output | 1 | Data-ready strobe, gated until the filter has settled |

## Verification
On every cycle the assertions check the local rules. The low pulse and the high force never overlap, and the low pulse lasts one clock. Power-down appears only inside a hold. A hold persists while the serial clock stays high and ends one clock after it falls. The gated ready strobe never appears during a hold. Only the bench scenarios can show the counting rules: the exact tick on which the hold begins, the 20-boundary power-down threshold, and the restart of the count after a low boundary. The same holds for the number of suppressed ready strobes after a release.

// File: rtl/sclk_idle_pkg.sv
package sclk_idle_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_PDN  = 2'd2
  } idle_mode_e;
endpackage

// File: rtl/sclk_hold_counter.sv
module sclk_hold_counter #(
  parameter int SYNC_CYC = 4,
  parameter int PD_CYC   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cyc_tick,
  output logic hit_sync,
  output logic hit_pd,
  output logic fall
);
  localparam int CW = $clog2(PD_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          sclk_q;

  assign fall     = sclk_q & ~sclk_s;
  assign cnt_inc  = (cnt_q == CW'(PD_CYC)) ? cnt_q : cnt_q + 1'b1;
  // completing boundary: the previous count was one short of the threshold
  assign hit_sync = cyc_tick & sclk_s & (cnt_q == CW'(SYNC_CYC - 1));
  assign hit_pd   = cyc_tick & sclk_s & (cnt_q == CW'(PD_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      if (fall)
        cnt_q <= '0;
      else if (cyc_tick)
        cnt_q <= sclk_s ? cnt_inc : '0;
    end
  end
endmodule

// File: rtl/sclk_mode_fsm.sv
module sclk_mode_fsm
  import sclk_idle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_sync,
  input  logic       hit_pd,
  input  logic       fall,
  output idle_mode_e mode,
  output logic       lo_pulse,
  output logic       release_p
);
  idle_mode_e mode_q, mode_d;
  logic       pulse_q;

  assign release_p = fall & (mode_q != MODE_RUN);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:  if (hit_sync) mode_d = MODE_HOLD;
      MODE_HOLD: if (fall) mode_d = MODE_RUN;
                 else if (hit_pd) mode_d = MODE_PDN;
      MODE_PDN:  if (fall) mode_d = MODE_RUN;
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_RUN;
      pulse_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      pulse_q <= (mode_q == MODE_RUN) & hit_sync;
    end
  end

  assign mode     = mode_q;
  assign lo_pulse = pulse_q;
endmodule

// File: rtl/sclk_settle_gate.sv
module sclk_settle_gate #(
  parameter int SETTLE_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cyc_tick,
  input  logic restart,
  input  logic rdy_in,
  output logic rdy_out
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= SW'(SETTLE_CYC);
    else if (restart)
      left_q <= SW'(SETTLE_CYC);
    else if (run && cyc_tick && left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign rdy_out = rdy_in & run & (left_q == '0);
endmodule

// File: rtl/sclk_idle_ctrl.sv
module sclk_idle_ctrl
  import sclk_idle_pkg::*;
#(
  parameter int SYNC_CYC   = 4,
  parameter int PD_CYC     = 20,
  parameter int SETTLE_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cyc_tick,
  input  logic rdy_in,
  output logic mod_rst,
  output logic pwr_dn,
  output logic pin_lo_req,
  output logic pin_hi_force,
  output logic rdy_out
);
  logic       hit_sync, hit_pd, fall, lo_pulse, release_p;
  idle_mode_e mode;

  sclk_hold_counter #(.SYNC_CYC(SYNC_CYC), .PD_CYC(PD_CYC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cyc_tick(cyc_tick),
    .hit_sync(hit_sync), .hit_pd(hit_pd), .fall(fall)
  );

  sclk_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hit_sync(hit_sync), .hit_pd(hit_pd),
    .fall(fall), .mode(mode), .lo_pulse(lo_pulse), .release_p(release_p)
  );

  sclk_settle_gate #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(mode == MODE_RUN), .cyc_tick(cyc_tick),
    .restart(release_p), .rdy_in(rdy_in), .rdy_out(rdy_out)
  );

  assign mod_rst      = (mode != MODE_RUN);
  assign pwr_dn       = (mode == MODE_PDN);
  assign pin_lo_req   = lo_pulse;
  assign pin_hi_force = (mode != MODE_RUN) & ~lo_pulse;
endmodule

// File: rtl/sclk_idle_chk.sv
module sclk_idle_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_s,
  input logic mod_rst,
  input logic pwr_dn,
  input logic pin_lo_req,
  input logic pin_hi_force,
  input logic rdy_out
);
  AST_LO_HI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_lo_req && pin_hi_force)); // R3
  AST_LO_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    pin_lo_req |=> !pin_lo_req); // R3
  AST_ENTRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_rst) |-> pin_lo_req); // R2
  AST_PD_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> mod_rst); // R4
  AST_PD_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_dn) |-> $past(mod_rst)); // R4
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_rst && sclk_s) |=> mod_rst); // R5
  AST_FALL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_rst && $fell(sclk_s)) |=> !mod_rst); // R5
  AST_RDY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_out |-> !mod_rst); // R7
endmodule

bind sclk_idle_ctrl sclk_idle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .mod_rst(mod_rst),
  .pwr_dn(pwr_dn), .pin_lo_req(pin_lo_req), .pin_hi_force(pin_hi_force),
  .rdy_out(rdy_out)
);

// File: tb/tb_sclk_idle_ctrl.sv
module tb_sclk_idle_ctrl;
  localparam int SYNC = 4;
  localparam int PD = 20;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_s = 1'b0, cyc_tick = 1'b0, rdy_in = 1'b0;
  logic mod_rst, pwr_dn, pin_lo_req, pin_hi_force, rdy_out;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  sclk_idle_ctrl #(.SYNC_CYC(SYNC), .PD_CYC(PD), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cyc_tick(cyc_tick),
    .rdy_in(rdy_in), .mod_rst(mod_rst), .pwr_dn(pwr_dn),
    .pin_lo_req(pin_lo_req), .pin_hi_force(pin_hi_force), .rdy_out(rdy_out)
  );

  always #10 clk = ~clk;

  // behavioural reference: 0 run, 1 hold, 2 power-down
  int m_mode = 0, m_cnt = 0, m_left = SETTLE;
  bit m_prev = 1'b0, m_pulse = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_left = SETTLE; m_prev = 1'b0; m_pulse = 1'b0;
    end else begin
      automatic bit fell = m_prev && !sclk_s;
      automatic int old_mode = m_mode;
      m_pulse = 1'b0;
      if (old_mode == 0 && cyc_tick && m_left > 0) m_left--;
      if (old_mode != 0 && fell) begin
        m_mode = 0; m_left = SETTLE;
      end else if (cyc_tick && sclk_s) begin
        if (old_mode == 0 && m_cnt + 1 == SYNC) begin m_mode = 1; m_pulse = 1'b1; end
        else if (old_mode == 1 && m_cnt + 1 == PD) m_mode = 2;
      end
      if (fell) m_cnt = 0;
      else if (cyc_tick) m_cnt = sclk_s ? ((m_cnt < PD) ? m_cnt + 1 : PD) : 0;
      m_prev = sclk_s;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 mod_rst", mod_rst, m_mode != 0);
    chk("R4 pwr_dn", pwr_dn, m_mode == 2);
    chk("R3 pin_lo_req", pin_lo_req, m_pulse);
    chk("R3 pin_hi_force", pin_hi_force, m_mode != 0 && !m_pulse);
    chk("R7 rdy_out", rdy_out, rdy_in && m_mode == 0 && m_left == 0);
  end

  task automatic drive(logic s, logic t, logic r);
    @(negedge clk); #2;
    sclk_s = s; cyc_tick = t; rdy_in = r;
  endtask

  // n conversions: tick cycle first, then three idle cycles at level s
  task automatic conv(int n, logic s, bit toggle = 1'b0);
    for (int i = 0; i < n; i++) begin
      drive(s, 1'b1, 1'b1);
      for (int k = 0; k < 3; k++) drive(toggle ? logic'(k[0] == 1'b0) : s, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 mod_rst", mod_rst, 1'b0);
    chk("R9 pwr_dn", pwr_dn, 1'b0);
    chk("R9 pin", pin_lo_req | pin_hi_force, 1'b0);
    conv(8, 1'b0);                 // settle after reset, R7
    conv(10, 1'b0, 1'b1);          // read clocking, R8
    drive(1'b0, 1'b0, 1'b0);
    chk("R8 no hold", mod_rst, 1'b0);
    conv(3, 1'b1); conv(1, 1'b0); conv(3, 1'b1);
    chk("R1 broken run", mod_rst, 1'b0);
    conv(1, 1'b0);
    conv(10, 1'b1);
    chk("R6 hold", mod_rst, 1'b1);
    chk("R6 no pd", pwr_dn, 1'b0);
    conv(1, 1'b0);
    chk("R5 release", mod_rst, 1'b0);
    conv(7, 1'b0);
    conv(19, 1'b1);
    chk("R4 not yet", pwr_dn, 1'b0);
    conv(1, 1'b1);
    chk("R4 pd", pwr_dn, 1'b1);
    conv(5, 1'b1);
    chk("R4 pd kept", pwr_dn, 1'b1);
    conv(1, 1'b0);
    chk("R5 pd release", pwr_dn, 1'b0);
    chk("R5 pin free", pin_hi_force, 1'b0);
    conv(8, 1'b0);
    conv(4, 1'b1);
    chk("R2 sync at 4", mod_rst, 1'b1);
    conv(1, 1'b0);
    conv(3, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule